// File: doc/BRIEF.md
# Masked Vector Mask Population Count and First-Set Search

This unit turns one VLEN-bit mask vector into a single XLEN-wide scalar. It has two operations. The population count gives the number of set bits among the active elements. The first-set search gives the element index of the lowest active set bit. An element is active when its index lies in the half-open window from the start index to the vector length and, when masking is on, its bit in the execution mask is set.

A command is issued with a one-cycle `start_i` pulse. That pulse carries the operation, the two mask vectors, the masking flag, the vector length and the start index. The unit copies all operands, then walks the mask in CHUNK-bit slices, one slice per clock. It always walks every slice, so the latency is fixed. It then raises `done_o` together with two side-effect strobes: `vstart_clr_o` tells the surrounding pipeline to zero its start index, and `vs_dirty_o` tells it to mark the vector state as modified.

The controller has three states. IDLE waits for a command. SCAN reduces one slice per cycle. FIN presents the completion pulse. The transitions are: IDLE to SCAN when `start_i` is seen, SCAN to SCAN while slices remain, SCAN to FIN after the last slice, and FIN to IDLE unconditionally. With VLEN/CHUNK slices, `done_o` is high in the cycle that follows the (VLEN/CHUNK)-th rising edge after the edge that sampled `start_i`. With the default parameters that is 8 cycles.

Top module: `mask_reduce`

## Requirements
- R1: Only elements with index i such that `vstart_i` <= i < `vl_i` take part in either operation. Elements below the start index or at or above the length are never counted and never returned.
- R2: When `vm_i` is 0, an element whose bit in `v0_i` is clear is skipped by both operations. When `vm_i` is 1, every element in the window is active and `v0_i` has no effect.
- R3: With `op_i` = 0 (count), `result_o` is the number of active elements whose `src_i` bit is set, zero-extended to XLEN.
- R4: With `op_i` = 1 (search), `result_o` is the index of the lowest-numbered active element whose `src_i` bit is set. Later set bits do not change it.
- R5: When the search finds no active set bit, `result_o` is all ones across the full XLEN width.
- R6: `done_o`, `vstart_clr_o` and `vs_dirty_o` are each a single-cycle pulse, all high in the same cycle. That cycle follows the (VLEN/CHUNK)-th rising edge after the edge that sampled `start_i`. `result_o` is valid in that cycle.
- R7: When `vl_i` <= `vstart_i`, the count returns 0 and the search returns all ones.
- R8: A `start_i` pulse seen while a command is in progress (SCAN or FIN) is ignored. `result_o` keeps its value from one completion pulse to the next and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, one cycle |
| op_i | input | 1 | 0 = population count, 1 = first-set search |
| vm_i | input | 1 | 1 = unmasked, 0 = use `v0_i` as execution mask |
| vl_i | input | $clog2(VLEN)+1 | Vector length in elements |
| vstart_i | input | $clog2(VLEN)+1 | First element index to consider |
| src_i | input | VLEN | Source mask vector, bit i is element i |
| v0_i | input | VLEN | Execution mask, bit i enables element i |
| done_o | output | 1 | Completion pulse |
| vstart_clr_o | output | 1 | Request to zero the start index, with `done_o` |
| vs_dirty_o | output | 1 | Request to mark vector state modified, with `done_o` |
| result_o | output | XLEN | Scalar result, held until the next completion |

## Verification
For every accepted command, the bench model expects the completion strobes and the new result exactly VLEN/CHUNK edges after the edge that sampled the command; with the default parameters that is 8. Both the model and the unit advance on rising edges. The outputs are compared with the model on every falling edge, so a pulse that is one cycle early or one cycle late is caught as a mismatch in both the strobe and the result. Between pulses, the model expects the previous result to stay unchanged. It also ignores any command issued while its own countdown is running, so a design that accepts such a command is caught.

// File: rtl/mask_reduce_pkg.sv
package mask_reduce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } red_state_e;

    typedef enum logic {
        OP_COUNT = 1'b0,
        OP_FIND  = 1'b1
    } red_op_e;
endpackage

// File: rtl/mask_reduce_window.sv
// Qualifies the bits of one slice: inside [vstart, vl), enabled by v0 when
// masking is on, and set in the source.
module mask_reduce_window #(
    parameter int CHUNK = 16,
    parameter int SELW  = 3,
    parameter int CW    = 8
) (
    input  logic [SELW-1:0]  sel_i,
    input  logic [CHUNK-1:0] src_i,
    input  logic [CHUNK-1:0] v0_i,
    input  logic             vm_i,
    input  logic [CW-1:0]    vl_i,
    input  logic [CW-1:0]    vstart_i,
    output logic [CHUNK-1:0] act_o
);
    localparam int LOGC = $clog2(CHUNK);

    for (genvar j = 0; j < CHUNK; j++) begin : g_bit
        logic [CW-1:0] gidx;
        assign gidx     = (CW'(sel_i) << LOGC) | CW'(j);
        assign act_o[j] = src_i[j] & (vm_i | v0_i[j]) &
                          (gidx >= vstart_i) & (gidx < vl_i);
    end
endmodule

// File: rtl/mask_reduce_slice.sv
// Population count and lowest set position of one qualified slice.
module mask_reduce_slice #(
    parameter int CHUNK = 16
) (
    input  logic [CHUNK-1:0]         act_i,
    output logic [$clog2(CHUNK):0]   pcnt_o,
    output logic                     hit_o,
    output logic [$clog2(CHUNK)-1:0] pos_o
);
    localparam int LOGC = $clog2(CHUNK);

    always_comb begin
        pcnt_o = '0;
        for (int i = 0; i < CHUNK; i++) begin
            pcnt_o = pcnt_o + (LOGC+1)'(act_i[i]);
        end
    end

    always_comb begin
        hit_o = 1'b0;
        pos_o = '0;
        for (int i = CHUNK - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                hit_o = 1'b1;
                pos_o = LOGC'(i);
            end
        end
    end

    // R4: the reported position must point at a qualified bit
    always_comb begin
        if (hit_o) begin
            p_pos_is_set_r4: assert (act_i[pos_o]);
        end
        p_cnt_vs_hit_r3: assert ((pcnt_o != '0) == hit_o);
    end
endmodule

// File: rtl/mask_reduce.sv
module mask_reduce
    import mask_reduce_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VLEN  = 128,
    parameter int CHUNK = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      op_i,
    input  logic                      vm_i,
    input  logic [$clog2(VLEN):0]     vl_i,
    input  logic [$clog2(VLEN):0]     vstart_i,
    input  logic [VLEN-1:0]           src_i,
    input  logic [VLEN-1:0]           v0_i,
    output logic                      done_o,
    output logic                      vstart_clr_o,
    output logic                      vs_dirty_o,
    output logic [XLEN-1:0]           result_o
);
    localparam int NCHUNK = VLEN / CHUNK;
    localparam int SELW   = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int LOGC   = $clog2(CHUNK);
    localparam int CW     = $clog2(VLEN) + 1;
    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    red_state_e           state_q, state_d;
    red_op_e              op_q;
    logic                 vm_q;
    logic [CW-1:0]        vl_q, vstart_q;
    logic [VLEN-1:0]      src_q, v0_q;
    logic [SELW-1:0]      sel_q;
    logic [CW-1:0]        cnt_q, cnt_d;
    logic [CW-1:0]        first_q, first_d;
    logic                 found_q, found_d;
    logic [XLEN-1:0]      res_q;

    logic [CHUNK-1:0]     src_sl, v0_sl, act;
    logic [LOGC:0]        pcnt;
    logic                 hit;
    logic [LOGC-1:0]      pos;
    logic                 last_sl;
    logic                 accept;

    // ---------------- slice selection and reduction ----------------
    assign src_sl  = src_q[CW'(sel_q) * CW'(CHUNK) +: CHUNK];
    assign v0_sl   = v0_q [CW'(sel_q) * CW'(CHUNK) +: CHUNK];
    assign last_sl = (sel_q == SELW'(NCHUNK - 1));
    assign accept  = (state_q == ST_IDLE) && start_i;

    mask_reduce_window #(
        .CHUNK (CHUNK),
        .SELW  (SELW),
        .CW    (CW)
    ) u_window (
        .sel_i    (sel_q),
        .src_i    (src_sl),
        .v0_i     (v0_sl),
        .vm_i     (vm_q),
        .vl_i     (vl_q),
        .vstart_i (vstart_q),
        .act_o    (act)
    );

    mask_reduce_slice #(
        .CHUNK (CHUNK)
    ) u_slice (
        .act_i  (act),
        .pcnt_o (pcnt),
        .hit_o  (hit),
        .pos_o  (pos)
    );

    // ---------------- accumulation ----------------
    always_comb begin
        cnt_d   = cnt_q + CW'(pcnt);
        found_d = found_q | hit;
        first_d = first_q;
        if (!found_q && hit) begin
            first_d = (CW'(sel_q) << LOGC) | CW'(pos);
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SCAN;
            ST_SCAN: if (last_sl) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_COUNT;
            vm_q     <= 1'b1;
            vl_q     <= '0;
            vstart_q <= '0;
            src_q    <= '0;
            v0_q     <= '0;
            sel_q    <= '0;
            cnt_q    <= '0;
            first_q  <= '0;
            found_q  <= 1'b0;
            res_q    <= '0;
        end else begin
            if (accept) begin
                op_q     <= red_op_e'(op_i);
                vm_q     <= vm_i;
                vl_q     <= vl_i;
                vstart_q <= vstart_i;
                src_q    <= src_i;
                v0_q     <= v0_i;
                sel_q    <= '0;
                cnt_q    <= '0;
                first_q  <= '0;
                found_q  <= 1'b0;
            end else if (state_q == ST_SCAN) begin
                sel_q   <= sel_q + SELW'(1);
                cnt_q   <= cnt_d;
                first_q <= first_d;
                found_q <= found_d;
                if (last_sl) begin
                    if (op_q == OP_FIND) res_q <= found_d ? XLEN'(first_d) : ALL_ONES;
                    else                 res_q <= XLEN'(cnt_d);
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        done_o       = 1'b0;
        vstart_clr_o = 1'b0;
        vs_dirty_o   = 1'b0;
        unique case (state_q)
            ST_FIN: begin
                done_o       = 1'b1;
                vstart_clr_o = 1'b1;
                vs_dirty_o   = 1'b1;
            end
            default: ;
        endcase
        result_o = res_q;
    end

    // ---------------- assertions ----------------
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_COUNT && vl_q > vstart_q) |->
            (result_o <= XLEN'(vl_q - vstart_q)));

    p_empty_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_COUNT && vl_q <= vstart_q) |-> (result_o == '0));

    p_empty_find_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_FIND && vl_q <= vstart_q) |-> (result_o == ALL_ONES));

    p_find_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_FIND && result_o != ALL_ONES) |->
            ((result_o >= XLEN'(vstart_q)) && (result_o < XLEN'(vl_q))));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=>
            ($stable(vl_q) && $stable(vstart_q) && $stable(src_q)));
endmodule

// File: tb/mask_reduce_test.sv
module mask_reduce_test;
    localparam int XLEN  = 64;
    localparam int VLEN  = 128;
    localparam int CHUNK = 16;
    localparam int LAT   = VLEN / CHUNK;
    localparam int CW    = $clog2(VLEN) + 1;
    localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            op_i = 1'b0;
    logic            vm_i = 1'b1;
    logic [CW-1:0]   vl_i = '0;
    logic [CW-1:0]   vstart_i = '0;
    logic [VLEN-1:0] src_i = '0;
    logic [VLEN-1:0] v0_i = '0;
    logic            done_o, vstart_clr_o, vs_dirty_o;
    logic [XLEN-1:0] result_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mask_reduce #(.XLEN(XLEN), .VLEN(VLEN), .CHUNK(CHUNK)) uut (
        .clk, .rst_n, .start_i, .op_i, .vm_i, .vl_i, .vstart_i,
        .src_i, .v0_i, .done_o, .vstart_clr_o, .vs_dirty_o, .result_o
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [XLEN-1:0] ref_calc(input bit op, input bit vm,
            input int vl, input int vs, input logic [VLEN-1:0] s,
            input logic [VLEN-1:0] m);
        int c = 0;
        int f = -1;
        for (int i = vs; i < vl; i++) begin
            if ((vm || m[i]) && s[i]) begin
                c++;
                if (f < 0) f = i;
            end
        end
        if (!op) return XLEN'(c);
        return (f < 0) ? ONES : XLEN'(f);
    endfunction

    bit              m_busy = 1'b0;
    int              m_rem = 0;
    logic [XLEN-1:0] m_pend = '0;
    logic [XLEN-1:0] m_res = '0;
    string           m_tag = "R3";
    string           cur_tag = "R3";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_rem  = 0;
            m_res  = '0;
        end else if (m_busy) begin
            if (m_rem == 0) m_busy = 1'b0;
            else begin
                m_rem--;
                if (m_rem == 0) m_res = m_pend;
            end
        end else if (start_i) begin
            m_pend = ref_calc(op_i, vm_i, int'(vl_i), int'(vstart_i), src_i, v0_i);
            m_tag  = cur_tag;
            m_busy = 1'b1;
            m_rem  = LAT;
        end
    end

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit ed;
            ed = m_busy && (m_rem == 0);
            check("R6", XLEN'(done_o), XLEN'(ed));
            check("R6", XLEN'(vstart_clr_o), XLEN'(ed));
            check("R6", XLEN'(vs_dirty_o), XLEN'(ed));
            check(ed ? m_tag : "R8", result_o, m_res);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic issue(input string tag, input bit op, input bit vm,
                         input int vl, input int vs,
                         input logic [VLEN-1:0] s, input logic [VLEN-1:0] m);
        @(negedge clk);
        cur_tag  = tag;
        op_i     = op;
        vm_i     = vm;
        vl_i     = CW'(vl);
        vstart_i = CW'(vs);
        src_i    = s;
        v0_i     = m;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic run(input string tag, input bit op, input bit vm,
                       input int vl, input int vs,
                       input logic [VLEN-1:0] s, input logic [VLEN-1:0] m);
        issue(tag, op, vm, vl, vs, s, m);
        repeat (LAT + 2) @(negedge clk);
    endtask

    initial begin
        logic [VLEN-1:0] alt, hi, r1, r2;
        alt = {(VLEN/2){2'b10}};
        hi  = '0;
        hi[VLEN-1] = 1'b1;
        repeat (3) @(negedge clk);
        // reset state (R8)
        check("R8", result_o, '0);
        check("R6", XLEN'(done_o), '0);
        rst_n = 1'b1;
        @(negedge clk);

        run("R3", 0, 1, VLEN, 0, '1, '0);                 // count all: VLEN
        run("R3", 0, 1, VLEN, 0, alt, '0);                // count odd bits
        run("R2", 0, 0, VLEN, 0, '1, alt);                // masked count
        run("R2", 0, 1, VLEN, 0, alt, '0);                // vm=1 ignores v0
        run("R1", 0, 1, 40, 9, '1, '0);                   // window count 31
        run("R4", 1, 1, VLEN, 0, alt, '0);                // first = 1
        run("R2", 1, 0, VLEN, 0, {{(VLEN-4){1'b1}}, 4'b0011}, {{(VLEN-4){1'b1}}, 4'b1100}); // first = 4
        run("R1", 1, 1, VLEN, 5, '1, '0);                 // first = vstart
        run("R4", 1, 1, VLEN, 0, hi, '0);                 // first = VLEN-1
        run("R5", 1, 1, VLEN, 0, '0, '0);                 // none: all ones
        run("R1", 1, 1, VLEN - 1, 0, hi, '0);             // bit beyond vl: all ones
        run("R7", 0, 1, 17, 17, '1, '0);                  // empty window count
        run("R7", 1, 1, 17, 17, '1, '0);                  // empty window search
        run("R7", 0, 1, 0, 0, '1, '0);

        // R8: command during busy is ignored
        issue("R8", 0, 1, VLEN, 0, '1, '0);
        repeat (3) @(negedge clk);
        cur_tag = "R8"; op_i = 1'b1; vl_i = CW'(3); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT + 2) @(negedge clk);

        for (int k = 0; k < 60; k++) begin
            int vl, vs;
            r1 = {$urandom, $urandom, $urandom, $urandom};
            r2 = {$urandom, $urandom, $urandom, $urandom};
            if (k % 3 == 0) r1 = r1 & r2 & {$urandom, $urandom, $urandom, $urandom};
            vl = $urandom_range(0, VLEN);
            vs = $urandom_range(0, vl);
            run((k % 2) ? "R4" : "R3", k[0], k[2], vl, vs, r1, r2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule